// File: doc/BRIEF.md
# UART Boot Command Frame Parser

This block sits behind a UART receiver and turns its byte stream into bootloader commands. It stays deaf until the receiver reports a line break. After that it hunts for a sync byte and reads a two-byte length, a one-byte checksum and the payload. It then decides what the frame means. Command results go to a small response generator, which serialises acknowledge, negative-acknowledge and status frames back toward the host. The payloads of the two write commands are passed downstream byte by byte, tagged with their destination. Flash and RAM writes and image-level integrity checks are done by the logic that consumes that stream.

The parser also tracks a single open file. An open command selects one of four image slots. Writes are accepted only while a file is open, and a close must name the slot that was opened. The result of every command except the two query commands is kept as a status byte, and the host can read it back later.

Back-pressure: the receive side has no ready signal, because a UART cannot be paused. The payload stream has no ready either, so its consumer must take one byte per strobe. Only the response stream is valid/ready. A response byte and its valid are held unchanged until the cycle in which ready is sampled high. A new response requested while one is still being sent is dropped. The protocol is request/response, so a well-behaved host never causes that.

Top module: `boot_frame_parser`

## Requirements
- R1: Before the first cycle with `rx_break` high, every received byte is discarded: no response, no payload strobe and no `pl_end` result from it.
- R2: A frame is sync byte 0xAA, a big-endian 16-bit length L, a checksum byte, then L-2 payload bytes whose first byte is the command code. Bytes other than 0xAA are skipped while hunting for a frame.
- R3: The checksum must equal the low 8 bits of the sum of all payload bytes. A mismatch gives a NACK and status 0x4B.
- R4: A length below 3 or above 256 ends the frame right after the second length byte, with a NACK and status 0x4C. Hunting for 0xAA resumes with the next byte.
- R5: A well-formed frame whose command code is not one of 0x20, 0x21, 0x22, 0x23, 0x24, 0x26, 0x28 or 0x2F gives a NACK and status 0x4D.
- R6: Ping (0x20) and erase (0x28) give an ACK and status 0x40. An ACK is the bytes 0x00 0x04 0xCC 0x00 0xCC. A NACK is 0x00 0x04 0x33 0x00 0x33.
- R7: Open (0x21) needs a 17-byte payload: the code, a 4-byte size and a big-endian 4-byte file type, then 8 reserved bytes. The wrong size gives status 0x4C. A type outside 4..7 gives status 0x50 and a NACK. Otherwise the block ACKs, sets `file_open` and sets `file_slot` to type minus 4.
- R8: With a file open, every payload byte after the code of a write command is output on `pl_data` with `pl_valid`, one cycle after it arrives. `pl_tag` is 0 for 0x24 (flash) and 1 for 0x26 (RAM). `pl_end` pulses together with the last byte, with `pl_good` set to the checksum result, and the response is an ACK if the checksum is good.
- R9: A write command that arrives while no file is open streams no bytes, produces no `pl_end` and gives a NACK with status 0x4E.
- R10: Close (0x22) takes a 5-byte payload: the code and a 4-byte file type. It gives status 0x4E if no file is open, and 0x4F with the file left open if the type does not match the open slot. Otherwise it ACKs and clears `file_open`.
- R11: Get status (0x23) returns 0x00 0x03 s s, where s is the stored status. Get version (0x2F) returns 0x00 0x03 v v with v = VERSION_ID. Neither command changes the stored status.
- R12: Response bytes are held stable while `rsp_valid` is high and `rsp_ready` is low. A response requested while another is still being sent is dropped.
- R13: After reset there is no response pending, no file is open and the stored status is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| rx_break | input | 1 | Line break detected by the UART receiver |
| pl_data | output | 8 | Write payload byte |
| pl_valid | output | 1 | `pl_data` valid strobe |
| pl_tag | output | 1 | Destination of the payload: 0 flash, 1 RAM |
| pl_end | output | 1 | End of a streamed write frame |
| pl_good | output | 1 | Checksum result of the ended write frame |
| rsp_data | output | 8 | Response byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Downstream accepts the response byte |
| file_open | output | 1 | A file is currently open |
| file_slot | output | 2 | Slot of the open file (type minus 4) |

## Verification
Some properties are checked on every cycle. Nothing leaves the parser before it is armed by a break. The payload index stays inside the 254-byte bound. A response byte does not move while it is stalled. A status query leaves the stored status untouched.

The meaning of each frame can only be shown by the bench's scenarios: ACK against NACK, the status codes, slot tracking across open, write and close, and the drop of a response requested while the generator is stalled. The bench predicts these from a small model of the protocol.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam logic [7:0] CMD_PING     = 8'h20;
  localparam logic [7:0] CMD_OPEN     = 8'h21;
  localparam logic [7:0] CMD_CLOSE    = 8'h22;
  localparam logic [7:0] CMD_STATUS   = 8'h23;
  localparam logic [7:0] CMD_WR_FLASH = 8'h24;
  localparam logic [7:0] CMD_WR_RAM   = 8'h26;
  localparam logic [7:0] CMD_ERASE    = 8'h28;
  localparam logic [7:0] CMD_VERSION  = 8'h2F;

  localparam logic [7:0] ST_NONE     = 8'h00;
  localparam logic [7:0] ST_OK       = 8'h40;
  localparam logic [7:0] ST_BAD_CSUM = 8'h4B;
  localparam logic [7:0] ST_BAD_LEN  = 8'h4C;
  localparam logic [7:0] ST_BAD_CMD  = 8'h4D;
  localparam logic [7:0] ST_NO_FILE  = 8'h4E;
  localparam logic [7:0] ST_MISMATCH = 8'h4F;
  localparam logic [7:0] ST_BAD_TYPE = 8'h50;

  localparam logic [7:0] ACK_CODE  = 8'hCC;
  localparam logic [7:0] NACK_CODE = 8'h33;

  typedef enum logic [1:0] {RSP_ACK, RSP_NACK, RSP_STAT} rsp_kind_t;

  typedef struct packed {
    logic        len_err;
    logic        csum_ok;
    logic        streamed;
    logic [7:0]  cmd;
    logic [31:0] ftype;
  } frame_info_t;

  function automatic logic is_write(input logic [7:0] c);
    return (c == CMD_WR_FLASH) || (c == CMD_WR_RAM);
  endfunction

  function automatic logic is_known(input logic [7:0] c);
    return (c == CMD_PING) || (c == CMD_OPEN) || (c == CMD_CLOSE) ||
           (c == CMD_STATUS) || is_write(c) || (c == CMD_ERASE) ||
           (c == CMD_VERSION);
  endfunction
endpackage

// File: rtl/frame_rx.sv
module frame_rx
  import boot_pkg::*;
#(
  parameter logic [7:0] SYNC_BYTE = 8'hAA,
  parameter int         MAX_LEN   = 256,
  localparam int        LW        = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  input  logic          rx_break,
  input  logic          file_open,
  output logic [7:0]    pl_data,
  output logic          pl_valid,
  output logic          pl_tag,
  output logic          done,
  output frame_info_t   info,
  output logic [LW-1:0] plen
);
  typedef enum logic [2:0] {S_HUNT, S_LHI, S_LLO, S_CSUM, S_PAY} rx_st_t;

  rx_st_t         st_q;
  logic           armed_q;
  logic [7:0]     len_hi_q, csum_q, sum_q, cmd_q;
  logic [LW-1:0]  rem_q, idx_q;
  logic [31:0]    ftype_q;
  logic           stream_q, tag_q;

  logic [15:0]    flen;
  logic [7:0]     sum_nx, cmd_nx;
  logic [31:0]    ftype_nx;
  logic           stream_nx, in_window;

  assign flen = {len_hi_q, rx_byte};

  always_comb begin
    sum_nx    = sum_q + rx_byte;
    cmd_nx    = (idx_q == '0) ? rx_byte : cmd_q;
    stream_nx = (idx_q == '0) ? (is_write(rx_byte) && file_open) : stream_q;
    in_window = ((cmd_q == CMD_OPEN)  && (idx_q >= LW'(5)) && (idx_q <= LW'(8))) ||
                ((cmd_q == CMD_CLOSE) && (idx_q >= LW'(1)) && (idx_q <= LW'(4)));
    ftype_nx  = (idx_q != '0 && in_window) ? {ftype_q[23:0], rx_byte} : ftype_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_HUNT;
      armed_q  <= 1'b0;
      len_hi_q <= '0;
      csum_q   <= '0;
      sum_q    <= '0;
      cmd_q    <= '0;
      rem_q    <= '0;
      idx_q    <= '0;
      ftype_q  <= '0;
      stream_q <= 1'b0;
      tag_q    <= 1'b0;
      pl_data  <= '0;
      pl_valid <= 1'b0;
      pl_tag   <= 1'b0;
      done     <= 1'b0;
      info     <= '0;
      plen     <= '0;
    end else begin
      pl_valid <= 1'b0;
      done     <= 1'b0;
      if (rx_break) begin
        armed_q <= 1'b1;
        st_q    <= S_HUNT;
      end else if (rx_valid && armed_q) begin
        unique case (st_q)
          S_HUNT: if (rx_byte == SYNC_BYTE) st_q <= S_LHI;
          S_LHI: begin
            len_hi_q <= rx_byte;
            st_q     <= S_LLO;
          end
          S_LLO: begin
            if (flen < 16'd3 || flen > 16'(MAX_LEN)) begin
              done         <= 1'b1;
              info         <= '0;
              info.len_err <= 1'b1;
              st_q         <= S_HUNT;
            end else begin
              rem_q <= LW'(flen - 16'd2);
              st_q  <= S_CSUM;
            end
          end
          S_CSUM: begin
            csum_q  <= rx_byte;
            sum_q   <= '0;
            idx_q   <= '0;
            ftype_q <= '0;
            st_q    <= S_PAY;
          end
          S_PAY: begin
            sum_q    <= sum_nx;
            cmd_q    <= cmd_nx;
            stream_q <= stream_nx;
            ftype_q  <= ftype_nx;
            idx_q    <= idx_q + 1'b1;
            rem_q    <= rem_q - 1'b1;
            if (idx_q == '0) begin
              tag_q <= (rx_byte == CMD_WR_RAM);
            end else if (stream_q) begin
              pl_valid <= 1'b1;
              pl_data  <= rx_byte;
              pl_tag   <= tag_q;
            end
            if (rem_q == LW'(1)) begin
              done          <= 1'b1;
              info.len_err  <= 1'b0;
              info.csum_ok  <= (sum_nx == csum_q);
              info.streamed <= stream_nx;
              info.cmd      <= cmd_nx;
              info.ftype    <= ftype_nx;
              plen          <= idx_q + 1'b1;
              st_q          <= S_HUNT;
            end
          end
          default: st_q <= S_HUNT;
        endcase
      end
    end
  end

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> (!pl_valid && !done)); // R1

  AST_PAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PAY) |-> (idx_q < LW'(MAX_LEN - 2))); // R2
endmodule

// File: rtl/cmd_tracker.sv
module cmd_tracker
  import boot_pkg::*;
#(
  parameter int         MAX_LEN    = 256,
  parameter logic [7:0] VERSION_ID = 8'h11,
  localparam int        LW         = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  frame_info_t   info,
  input  logic [LW-1:0] plen,
  output logic          file_open,
  output logic [1:0]    file_slot,
  output logic          rsp_req,
  output rsp_kind_t     rsp_kind,
  output logic [7:0]    rsp_byte,
  output logic          pl_end,
  output logic          pl_good
);
  logic [7:0] status_q, st_new;
  logic       upd, do_open, do_close, type_ok;

  assign type_ok = (info.ftype >= 32'd4) && (info.ftype <= 32'd7);

  always_comb begin
    st_new   = ST_OK;
    upd      = 1'b1;
    do_open  = 1'b0;
    do_close = 1'b0;
    rsp_byte = 8'h00;
    if (info.len_err)        st_new = ST_BAD_LEN;
    else if (!info.csum_ok)  st_new = ST_BAD_CSUM;
    else if (!is_known(info.cmd)) st_new = ST_BAD_CMD;
    else begin
      unique case (info.cmd)
        CMD_OPEN: begin
          if (plen != LW'(17)) st_new = ST_BAD_LEN;
          else if (!type_ok)   st_new = ST_BAD_TYPE;
          else                 do_open = 1'b1;
        end
        CMD_CLOSE: begin
          if (plen != LW'(5))  st_new = ST_BAD_LEN;
          else if (!file_open) st_new = ST_NO_FILE;
          else if (!type_ok || info.ftype[1:0] != file_slot) st_new = ST_MISMATCH;
          else                 do_close = 1'b1;
        end
        CMD_WR_FLASH, CMD_WR_RAM: if (!info.streamed) st_new = ST_NO_FILE;
        CMD_STATUS: begin
          upd      = 1'b0;
          rsp_byte = status_q;
        end
        CMD_VERSION: begin
          upd      = 1'b0;
          rsp_byte = VERSION_ID;
        end
        default: st_new = ST_OK;
      endcase
    end
    if (!upd)                rsp_kind = RSP_STAT;
    else if (st_new == ST_OK) rsp_kind = RSP_ACK;
    else                     rsp_kind = RSP_NACK;
  end

  assign rsp_req = done;
  assign pl_end  = done && info.streamed && !info.len_err;
  assign pl_good = info.csum_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= ST_NONE;
      file_open <= 1'b0;
      file_slot <= '0;
    end else if (done) begin
      if (upd) status_q <= st_new;
      if (do_open) begin
        file_open <= 1'b1;
        file_slot <= info.ftype[1:0];
      end else if (do_close) begin
        file_open <= 1'b0;
      end
    end
  end

  AST_QUERY_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !info.len_err && info.csum_ok && info.cmd == CMD_STATUS) |=> $stable(status_q)); // R11

  AST_CLOSE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!file_open && !(done && info.cmd == CMD_OPEN)) |=> !file_open); // R10
endmodule

// File: rtl/resp_gen.sv
module resp_gen
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  rsp_kind_t  kind,
  input  logic [7:0] sbyte,
  output logic [7:0] rsp_data,
  output logic       rsp_valid,
  input  logic       rsp_ready
);
  rsp_kind_t  kind_q;
  logic [7:0] byte_q, code;
  logic [2:0] pos_q, last;
  logic       busy_q;

  assign last      = (kind_q == RSP_STAT) ? 3'd3 : 3'd4;
  assign code      = (kind_q == RSP_ACK) ? ACK_CODE : NACK_CODE;
  assign rsp_valid = busy_q;

  always_comb begin
    rsp_data = 8'h00;
    if (kind_q == RSP_STAT) begin
      unique case (pos_q)
        3'd1:       rsp_data = 8'h03;
        3'd2, 3'd3: rsp_data = byte_q;
        default:    rsp_data = 8'h00;
      endcase
    end else begin
      unique case (pos_q)
        3'd1:       rsp_data = 8'h04;
        3'd2, 3'd4: rsp_data = code;
        default:    rsp_data = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= RSP_ACK;
      byte_q <= '0;
      pos_q  <= '0;
    end else if (!busy_q) begin
      if (req) begin
        busy_q <= 1'b1;
        kind_q <= kind;
        byte_q <= sbyte;
        pos_q  <= '0;
      end
    end else if (rsp_ready) begin
      if (pos_q == last) busy_q <= 1'b0;
      else               pos_q  <= pos_q + 1'b1;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R12

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pos_q <= 3'd4)); // R12
endmodule

// File: rtl/boot_frame_parser.sv
module boot_frame_parser
  import boot_pkg::*;
#(
  parameter logic [7:0] SYNC_BYTE  = 8'hAA,
  parameter int         MAX_LEN    = 256,
  parameter logic [7:0] VERSION_ID = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] rx_byte,
  input  logic       rx_valid,
  input  logic       rx_break,
  output logic [7:0] pl_data,
  output logic       pl_valid,
  output logic       pl_tag,
  output logic       pl_end,
  output logic       pl_good,
  output logic [7:0] rsp_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic       file_open,
  output logic [1:0] file_slot
);
  localparam int LW = $clog2(MAX_LEN + 1);

  logic          done, rsp_req;
  frame_info_t   info;
  logic [LW-1:0] plen;
  rsp_kind_t     rsp_kind;
  logic [7:0]    rsp_byte;

  frame_rx #(.SYNC_BYTE(SYNC_BYTE), .MAX_LEN(MAX_LEN)) i_rx (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_break(rx_break), .file_open(file_open), .pl_data(pl_data),
    .pl_valid(pl_valid), .pl_tag(pl_tag), .done(done), .info(info), .plen(plen)
  );

  cmd_tracker #(.MAX_LEN(MAX_LEN), .VERSION_ID(VERSION_ID)) i_trk (
    .clk(clk), .rst_n(rst_n), .done(done), .info(info), .plen(plen),
    .file_open(file_open), .file_slot(file_slot), .rsp_req(rsp_req),
    .rsp_kind(rsp_kind), .rsp_byte(rsp_byte), .pl_end(pl_end), .pl_good(pl_good)
  );

  resp_gen i_rsp (
    .clk(clk), .rst_n(rst_n), .req(rsp_req), .kind(rsp_kind), .sbyte(rsp_byte),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready)
  );
endmodule

// File: tb/test_boot_frame_parser.sv
module test_boot_frame_parser;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] VER = 8'h11;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0, rx_break = 1'b0, rsp_ready = 1'b1;
  logic [7:0] pl_data, rsp_data;
  logic pl_valid, pl_tag, pl_end, pl_good, rsp_valid, file_open;
  logic [1:0] file_slot;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] rq[$];  string rq_r[$];
  logic [8:0] pq[$];
  logic       eq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_frame_parser #(.VERSION_ID(VER)) i_boot_frame_parser (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_break(rx_break), .pl_data(pl_data), .pl_valid(pl_valid), .pl_tag(pl_tag),
    .pl_end(pl_end), .pl_good(pl_good), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .file_open(file_open), .file_slot(file_slot)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid && rsp_ready) begin
      if (rq.size() == 0) chk("R12 unexpected response byte", {24'd0, rsp_data}, 32'hFFFF);
      else chk(rq_r.pop_front(), {24'd0, rsp_data}, {24'd0, rq.pop_front()});
    end
    if (pl_valid) begin
      if (pq.size() == 0) chk("R8 unexpected payload", {23'd0, pl_tag, pl_data}, 32'hFFFF);
      else chk("R8 payload tag/data", {23'd0, pl_tag, pl_data}, {23'd0, pq.pop_front()});
    end
    if (pl_end) begin
      if (eq.size() == 0) chk("R9 unexpected pl_end", 1, 0);
      else chk("R8 pl_good", {31'd0, pl_good}, {31'd0, eq.pop_front()});
    end
  end

  task automatic exp_frame(input string r, input bq_t b);
    foreach (b[i]) begin rq.push_back(b[i]); rq_r.push_back(r); end
  endtask
  task automatic exp_ack(input string r);  exp_frame(r, '{8'h00, 8'h04, 8'hCC, 8'h00, 8'hCC}); endtask
  task automatic exp_nack(input string r); exp_frame(r, '{8'h00, 8'h04, 8'h33, 8'h00, 8'h33}); endtask
  task automatic exp_stat(input string r, input logic [7:0] s); exp_frame(r, '{8'h00, 8'h03, s, s}); endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_break();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic send_raw(input bq_t p, input logic [15:0] len, input logic [7:0] cs);
    send_byte(8'hAA); send_byte(len[15:8]); send_byte(len[7:0]); send_byte(cs);
    foreach (p[i]) send_byte(p[i]);
  endtask

  function automatic logic [7:0] csum(input bq_t p);
    logic [7:0] s = 8'h00;
    foreach (p[i]) s += p[i];
    return s;
  endfunction

  task automatic send_frame(input bq_t p);
    send_raw(p, 16'(p.size() + 2), csum(p));
  endtask

  task automatic settle(); repeat (12) @(negedge clk); endtask

  bq_t open5, open9, openshort, close5, close6;

  initial begin
    open5     = '{8'h21, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h05,
                  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    open9     = open5; open9[8] = 8'h09;
    openshort = '{8'h21, 8'h00, 8'h00, 8'h00, 8'h05};
    close5    = '{8'h22, 8'h00, 8'h00, 8'h00, 8'h05};
    close6    = '{8'h22, 8'h00, 8'h00, 8'h00, 8'h06};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 rsp_valid after reset", {31'd0, rsp_valid}, 0);
    chk("R13 file_open after reset", {31'd0, file_open}, 0);
    chk("R13 pl_valid after reset", {31'd0, pl_valid}, 0);

    // R1 frames before break are discarded
    send_frame('{8'h20});
    send_frame('{8'h24, 8'h01});
    settle();
    chk("R1 nothing produced before break", rq.size() + pq.size(), 0);

    send_break();
    // R13 stored status is 0x00 after reset
    exp_stat("R13 initial status", 8'h00); send_frame('{8'h23});
    // R2 garbage skipped, R6 ping ACK
    send_byte(8'h11); send_byte(8'h55);
    exp_ack("R6 ping ACK"); send_frame('{8'h20});
    exp_stat("R11 status after ping", 8'h40); send_frame('{8'h23});
    exp_stat("R11 query keeps status", 8'h40); send_frame('{8'h23});
    // R3 bad checksum
    exp_nack("R3 bad checksum NACK"); send_raw('{8'h20}, 16'd3, 8'h21);
    exp_stat("R3 status 0x4B", 8'h4B); send_frame('{8'h23});
    // R4 bad lengths, resync
    exp_nack("R4 length 2 NACK"); send_byte(8'hAA); send_byte(8'h00); send_byte(8'h02);
    exp_ack("R4 resync after short length"); send_frame('{8'h20});
    exp_nack("R4 length 257 NACK"); send_byte(8'hAA); send_byte(8'h01); send_byte(8'h01);
    exp_stat("R4 status 0x4C", 8'h4C); send_frame('{8'h23});
    // R5 unknown command
    exp_nack("R5 unknown cmd NACK"); send_frame('{8'h55, 8'h01});
    exp_stat("R5 status 0x4D", 8'h4D); send_frame('{8'h23});
    // R9 write without open file
    exp_nack("R9 write no file NACK"); send_frame('{8'h24, 8'h01, 8'h02});
    exp_stat("R9 status 0x4E", 8'h4E); send_frame('{8'h23});
    // R7 open variants
    exp_nack("R7 bad type NACK"); send_frame(open9);
    exp_stat("R7 status 0x50", 8'h50); send_frame('{8'h23});
    exp_nack("R7 short open NACK"); send_frame(openshort);
    exp_stat("R7 short open status 0x4C", 8'h4C); send_frame('{8'h23});
    chk("R7 still closed", {31'd0, file_open}, 0);
    exp_ack("R7 open ACK"); send_frame(open5);
    settle();
    chk("R7 file_open", {31'd0, file_open}, 1);
    chk("R7 file_slot", {30'd0, file_slot}, 1);
    // R8 writes
    pq.push_back(9'h0A1); pq.push_back(9'h0B2); pq.push_back(9'h0C3); eq.push_back(1'b1);
    exp_ack("R8 flash write ACK"); send_frame('{8'h24, 8'hA1, 8'hB2, 8'hC3});
    pq.push_back(9'h155); pq.push_back(9'h1AA); eq.push_back(1'b1);
    exp_ack("R8 RAM write ACK"); send_frame('{8'h26, 8'h55, 8'hAA});
    pq.push_back(9'h001); eq.push_back(1'b0);
    exp_nack("R8 bad checksum write NACK"); send_raw('{8'h24, 8'h01}, 16'd4, 8'h00);
    // R10 close variants
    exp_nack("R10 close mismatch NACK"); send_frame(close6);
    exp_stat("R10 status 0x4F", 8'h4F); send_frame('{8'h23});
    settle();
    chk("R10 file stays open", {31'd0, file_open}, 1);
    exp_ack("R10 close ACK"); send_frame(close5);
    settle();
    chk("R10 file closed", {31'd0, file_open}, 0);
    exp_nack("R10 close without open NACK"); send_frame(close5);
    // R11 version, status unchanged
    exp_stat("R11 version", VER); send_frame('{8'h2F});
    exp_stat("R11 status after version", 8'h4E); send_frame('{8'h23});
    settle();
    // R12 back-pressure and drop
    rsp_ready = 1'b0;
    exp_ack("R12 held ACK"); send_frame('{8'h28});
    begin
      logic [7:0] held;
      held = rsp_data;
      chk("R12 valid while stalled", {31'd0, rsp_valid}, 1);
      send_frame('{8'h20});
      settle();
      chk("R12 valid held", {31'd0, rsp_valid}, 1);
      chk("R12 data held", {24'd0, rsp_data}, {24'd0, held});
    end
    rsp_ready = 1'b1;
    settle();
    exp_ack("R6 erase ACK"); send_frame('{8'h28});
    settle();
    chk("R12 all responses seen", rq.size(), 0);
    chk("R8 all payload seen", pq.size() + eq.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule